// File: doc/BRIEF.md
# Auto-Incrementing Host RAM Address Pointer

This block lets a host processor walk through a 2K x 8 buffer RAM without sending an address for every byte. The host loads an 11-bit pointer through two 8-bit registers. The upper register holds a direction flag, an auto-advance enable and the top three address bits. The lower register holds the bottom eight address bits. Each host data access then uses the pointer as the RAM address and the direction flag as the access type. When auto-advance is on, the pointer steps forward after the access.

In 16-bit mode, address bit 0 no longer picks a byte. It becomes a swap control that decides which byte of an even/odd RAM pair travels on the upper host lane and which on the lower one. What that swap value means depends on the host bus style. When the pointer is loaded with the read direction set, the block emits a one-cycle prefetch strobe, so the RAM can fetch the addressed byte before the first data read.

Top module: `host_ram_ptr`

## Requirements
- R1: After reset, ram_addr is 0, ram_read is 0, prefetch is 0 and auto-advance is disabled: a data access leaves ram_addr unchanged.
- R2: A write to the upper register (reg_sel=1) loads bit 7 into ram_read (1 = read, 0 = write), bit 6 into the auto-advance enable and bits 2..0 into ram_addr[10:8]. ram_addr[7:0] is kept, and the result is visible the cycle after the write.
- R3: A write to the lower register (reg_sel=0) loads reg_wdata into ram_addr[7:0] and keeps ram_addr[10:8], ram_read and the auto-advance enable.
- R4: A data access with auto-advance enabled moves ram_addr forward by 1 in 8-bit mode and by 2 in 16-bit mode, modulo 2048. With auto-advance disabled, ram_addr holds its value.
- R5: Bits 5..3 of an upper-register write have no effect on any output.
- R6: If a register write and a data access occur in the same cycle, the register write takes effect and the pointer does not advance.
- R7: prefetch is high for exactly the one cycle after a lower-register write made while ram_read was 1. It is low at all other times.
- R8: In 16-bit mode the swap bit is ram_addr[0]. The odd byte (ram_odd_rd) goes on host_rdata[15:8] and the even byte on host_rdata[7:0] when bus_style=0 and swap=0, or when bus_style=1 and swap=1. In the other two cases the lanes are exchanged.
- R9: In 16-bit mode, host write data follows the same lane mapping as R8. The odd RAM byte takes the lane that carries the odd byte on reads. During a data access with ram_read=0, both we_even and we_odd are high.
- R10: In 8-bit mode, host_rdata is {8'h00, byte}, where the byte is ram_even_rd when ram_addr[0]=0 and ram_odd_rd when ram_addr[0]=1. Both write lanes carry host_wdata[7:0]. Only the write enable of the lane picked by ram_addr[0] rises, and only during a data access with ram_read=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 1 = upper register, 0 = lower register |
| reg_wdata | input | 8 | Register write data |
| data_acc | input | 1 | Host data access strobe, one cycle per access |
| wide_mode | input | 1 | 1 = 16-bit host accesses |
| bus_style | input | 1 | 0 = read/write-strobe host bus, 1 = direction/data-strobe host bus |
| ram_even_rd | input | 8 | RAM byte at the even address of the pair |
| ram_odd_rd | input | 8 | RAM byte at the odd address of the pair |
| host_wdata | input | 16 | Host write data |
| ram_addr | output | 11 | Current pointer, used as the RAM address |
| ram_read | output | 1 | Access direction, 1 = read |
| prefetch | output | 1 | One-cycle read-ahead strobe |
| host_rdata | output | 16 | Read data steered onto the host lanes |
| ram_even_wd | output | 8 | Write data for the even RAM byte |
| ram_odd_wd | output | 8 | Write data for the odd RAM byte |
| we_even | output | 1 | Write enable for the even RAM byte |
| we_odd | output | 1 | Write enable for the odd RAM byte |

## Verification
The hardest case to reach is a 16-bit access with an odd pointer that sits at the top of the address space. There the pointer has to step by two, wrap to the bottom and keep its swap bit. The stimulus loads the pointer to 2047 with auto-advance on and 16-bit mode selected. It then runs accesses under both bus styles, so the wrap, the preserved swap bit and the exchanged lanes all show up in the same few cycles. The bench also issues a register write in the same cycle as a data access, to show which of the two wins.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  typedef enum logic {STYLE_STROBE = 1'b0, STYLE_DIRDS = 1'b1} bus_style_e;

  // True when the odd byte of a pair rides on the upper host lane.
  function automatic logic odd_on_high(input bus_style_e s, input logic swap);
    return (s == STYLE_STROBE) ? ~swap : swap;
  endfunction
endpackage

// File: rtl/hrp_ptr_regs.sv
module hrp_ptr_regs #(
  parameter int ADDR_W = 11,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              data_acc,
  input  logic              wide,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              dir_q,
  output logic              prefetch_q
);
  localparam int HI_W    = ADDR_W - BYTE_W;
  localparam int DIR_BIT = BYTE_W - 1;
  localparam int AI_BIT  = BYTE_W - 2;

  logic ai_q;
  logic low_wr, high_wr, adv;

  function automatic logic [ADDR_W-1:0] next_ptr(input logic [ADDR_W-1:0] p, input logic w);
    return p + (w ? ADDR_W'(2) : ADDR_W'(1));
  endfunction

  assign low_wr  = reg_wr & ~reg_sel;
  assign high_wr = reg_wr & reg_sel;
  assign adv     = data_acc & ai_q & ~reg_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      dir_q      <= 1'b0;
      ai_q       <= 1'b0;
      prefetch_q <= 1'b0;
    end else begin
      if (high_wr) begin
        dir_q                <= reg_wdata[DIR_BIT];
        ai_q                 <= reg_wdata[AI_BIT];
        ptr_q[ADDR_W-1:BYTE_W] <= reg_wdata[HI_W-1:0];
      end
      if (low_wr) ptr_q[BYTE_W-1:0] <= reg_wdata;
      if (adv) ptr_q <= next_ptr(ptr_q, wide);
      prefetch_q <= low_wr & dir_q;
    end
  end

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !(data_acc && ai_q)) |=> $stable(ptr_q));
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr_q == next_ptr($past(ptr_q), $past(wide)));
  // R7
  prefetch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch_q |-> $past(low_wr && dir_q));
  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    high_wr |=> dir_q == $past(reg_wdata[DIR_BIT]));
  // R6
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_wr && data_acc) |=> ptr_q[BYTE_W-1:0] == $past(reg_wdata));
endmodule

// File: rtl/hrp_lane_steer.sv
module hrp_lane_steer #(
  parameter int BYTE_W = 8
) (
  input  hrp_pkg::bus_style_e   style,
  input  logic                  wide,
  input  logic                  swap,
  input  logic                  data_acc,
  input  logic                  dir,
  input  logic [BYTE_W-1:0]     ram_even,
  input  logic [BYTE_W-1:0]     ram_odd,
  input  logic [2*BYTE_W-1:0]   host_wdata,
  output logic [2*BYTE_W-1:0]   host_rdata,
  output logic [BYTE_W-1:0]     wr_even,
  output logic [BYTE_W-1:0]     wr_odd,
  output logic                  we_even,
  output logic                  we_odd
);
  localparam int WORD_W = 2 * BYTE_W;

  logic odd_hi, wr_acc;

  assign odd_hi = hrp_pkg::odd_on_high(style, swap);
  assign wr_acc = data_acc & ~dir;

  always_comb begin
    if (wide) begin
      host_rdata = odd_hi ? {ram_odd, ram_even} : {ram_even, ram_odd};
      wr_odd     = odd_hi ? host_wdata[WORD_W-1:BYTE_W] : host_wdata[BYTE_W-1:0];
      wr_even    = odd_hi ? host_wdata[BYTE_W-1:0] : host_wdata[WORD_W-1:BYTE_W];
    end else begin
      host_rdata = {{BYTE_W{1'b0}}, (swap ? ram_odd : ram_even)};
      wr_odd     = host_wdata[BYTE_W-1:0];
      wr_even    = host_wdata[BYTE_W-1:0];
    end
  end

  assign we_even = wr_acc & (wide | ~swap);
  assign we_odd  = wr_acc & (wide | swap);

  always_comb begin
    // R8
    if (wide) wide_perm_chk: assert ((host_rdata == {ram_odd, ram_even}) ||
                                     (host_rdata == {ram_even, ram_odd}));
    // R10
    if (!wide) narrow_we_chk: assert ($onehot0({we_even, we_odd}));
  end
endmodule

// File: rtl/host_ram_ptr.sv
module host_ram_ptr #(
  parameter int ADDR_W = 11,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_sel,
  input  logic [BYTE_W-1:0]   reg_wdata,
  input  logic                data_acc,
  input  logic                wide_mode,
  input  logic                bus_style,
  input  logic [BYTE_W-1:0]   ram_even_rd,
  input  logic [BYTE_W-1:0]   ram_odd_rd,
  input  logic [2*BYTE_W-1:0] host_wdata,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic                ram_read,
  output logic                prefetch,
  output logic [2*BYTE_W-1:0] host_rdata,
  output logic [BYTE_W-1:0]   ram_even_wd,
  output logic [BYTE_W-1:0]   ram_odd_wd,
  output logic                we_even,
  output logic                we_odd
);
  logic swap_bit;

  hrp_ptr_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .data_acc(data_acc), .wide(wide_mode),
    .ptr_q(ram_addr), .dir_q(ram_read), .prefetch_q(prefetch)
  );

  assign swap_bit = ram_addr[0];

  hrp_lane_steer #(.BYTE_W(BYTE_W)) u_lanes (
    .style(hrp_pkg::bus_style_e'(bus_style)), .wide(wide_mode), .swap(swap_bit),
    .data_acc(data_acc), .dir(ram_read), .ram_even(ram_even_rd), .ram_odd(ram_odd_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .wr_even(ram_even_wd),
    .wr_odd(ram_odd_wd), .we_even(we_even), .we_odd(we_odd)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk) $fell(rst_n) |=> (ram_addr == '0 && !ram_read));
endmodule

// File: tb/sim_host_ram_ptr.sv
`timescale 1ns/1ps
module sim_host_ram_ptr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_sel = 0, data_acc = 0, wide_mode = 0, bus_style = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  ram_even_rd = 8'hA5, ram_odd_rd = 8'h3C;
  logic [15:0] host_wdata = 16'h1234;
  logic [10:0] ram_addr;
  logic ram_read, prefetch, we_even, we_odd;
  logic [15:0] host_rdata;
  logic [7:0]  ram_even_wd, ram_odd_wd;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_ptr = 0;
  bit m_dir = 0, m_ai = 0, m_pf = 0;

  always #5 clk = ~clk;

  host_ram_ptr u0 (.*);

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    bit odd_hi, sw;
    longint rd, ew, ow;
    bit e_we_e, e_we_o;
    sw = (m_ptr % 2) == 1;
    case ({bus_style, sw})
      2'b00: odd_hi = 1;
      2'b01: odd_hi = 0;
      2'b10: odd_hi = 0;
      default: odd_hi = 1;
    endcase
    if (wide_mode) begin
      rd = odd_hi ? ram_odd_rd * 256 + ram_even_rd : ram_even_rd * 256 + ram_odd_rd;
      ow = odd_hi ? host_wdata / 256 : host_wdata % 256;
      ew = odd_hi ? host_wdata % 256 : host_wdata / 256;
      e_we_e = data_acc && !m_dir;
      e_we_o = data_acc && !m_dir;
    end else begin
      rd = sw ? ram_odd_rd : ram_even_rd;
      ow = host_wdata % 256;
      ew = host_wdata % 256;
      e_we_e = data_acc && !m_dir && !sw;
      e_we_o = data_acc && !m_dir && sw;
    end
    chk(tag, "ram_addr", ram_addr, m_ptr);
    chk(tag, "ram_read", ram_read, m_dir);
    chk(tag, "prefetch", prefetch, m_pf);
    chk(tag, "host_rdata", host_rdata, rd);
    chk(tag, "ram_even_wd", ram_even_wd, ew);
    chk(tag, "ram_odd_wd", ram_odd_wd, ow);
    chk(tag, "we_even", we_even, e_we_e);
    chk(tag, "we_odd", we_odd, e_we_o);
  endtask

  // One clock: drive at negedge, update model at posedge, compare 1 ns later.
  task automatic cyc(input bit rw, input bit sel, input logic [7:0] d, input bit acc, input string tag);
    bit old_dir;
    @(negedge clk);
    reg_wr = rw; reg_sel = sel; reg_wdata = d; data_acc = acc;
    @(posedge clk);
    old_dir = m_dir;
    m_pf = 0;
    if (rw && sel) begin
      m_dir = d[7]; m_ai = d[6];
      m_ptr = (d % 8) * 256 + (m_ptr % 256);
    end else if (rw) begin
      m_ptr = (m_ptr / 256) * 256 + d;
      m_pf = old_dir;
    end else if (acc && m_ai) begin
      m_ptr = (m_ptr + (wide_mode ? 2 : 1)) % 2048;
    end
    #1 compare(tag);
    @(negedge clk);
    reg_wr = 0; data_acc = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1 compare("R1");
    cyc(0, 0, 8'h00, 1, "R1");
    cyc(1, 1, 8'h85, 0, "R2");
    cyc(1, 0, 8'h3C, 0, "R3");
    cyc(0, 0, 8'h00, 0, "R7");
    cyc(1, 1, 8'hBD, 0, "R5");
    cyc(0, 0, 8'h00, 1, "R5");
    // narrow write with auto-advance
    cyc(1, 1, 8'h40, 0, "R2");
    cyc(1, 0, 8'hFE, 0, "R7");
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'h00, 1, "R10");
    cyc(1, 1, 8'h47, 0, "R2");
    cyc(1, 0, 8'hFF, 0, "R3");
    cyc(0, 0, 8'h00, 1, "R4");
    cyc(1, 0, 8'h10, 1, "R6");
    cyc(1, 1, 8'hC0, 1, "R6");
    cyc(0, 0, 8'h00, 1, "R10");
    // wide reads, both styles, both swap values, across the wrap
    @(negedge clk) wide_mode = 1;
    for (int s = 0; s < 2; s++) begin
      @(negedge clk) bus_style = s[0];
      cyc(1, 1, 8'hC7, 0, "R2");
      cyc(1, 0, 8'hFE, 0, "R7");
      cyc(0, 0, 8'h00, 1, "R8");
      cyc(0, 0, 8'h00, 1, "R4");
      cyc(1, 1, 8'hC7, 0, "R2");
      cyc(1, 0, 8'hFF, 0, "R7");
      cyc(0, 0, 8'h00, 1, "R8");
      cyc(0, 0, 8'h00, 1, "R4");
    end
    // wide writes
    @(negedge clk) host_wdata = 16'hBEEF;
    for (int s = 0; s < 2; s++) begin
      @(negedge clk) bus_style = s[0];
      cyc(1, 1, 8'h40, 0, "R2");
      cyc(1, 0, 8'h20, 0, "R3");
      cyc(0, 0, 8'h00, 1, "R9");
      cyc(1, 0, 8'h21, 0, "R3");
      cyc(0, 0, 8'h00, 1, "R9");
    end
    @(negedge clk) wide_mode = 0; host_wdata = 16'h5A77;
    cyc(1, 0, 8'h33, 0, "R7");
    cyc(0, 0, 8'h00, 1, "R10");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule